// File: doc/BRIEF.md
# Two-Wiper Register Target on an I2C Bus

This block is the serial front end of a device that keeps three six-bit settings: two wiper positions and one configuration value. It watches the I2C clock and data lines from the system clock and finds START and STOP conditions. It answers one 7-bit address, takes in data bytes and drives the data line low through an open-drain enable when it acknowledges or sends a zero.

A write transaction can hold any number of data bytes. Each data byte names its destination in its two upper bits, so one transaction can update both wipers and the configuration value. A read transaction returns the three settings in a fixed cycle, for as long as the controller keeps acknowledging. A busy input, raised by the storage side while a nonvolatile update is in progress, makes the block refuse its own address. A controller can therefore poll until the device answers.

At each STOP that closes a write transaction the block gives a one-cycle completion pulse. A flag in the same cycle says whether any stored value actually changed.

Top module: `wpot_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 0101 followed by `addr_pins[2:0]`. Bit 0 of the address byte selects read (1) or write (0).
- R2: Bytes move most significant bit first. After every accepted address byte and every write data byte, the block holds SDA low for the ninth clock. `sda_oe` only changes while the synchronized SCL is low.
- R3: After an address that does not match, the block gives no acknowledge and ignores all bytes until the next START, so stored values stay unchanged.
- R4: Read bytes come out as pot0, pot1, config, pot0, ... for as long as the controller ACKs. Each byte is {select, value}, with select 00 for pot0, 01 for pot1 and 10 for config in bits 7:6, and the six-bit value in bits 5:0.
- R5: Every START, including a repeated START, resets the read order to pot0, so a single-byte read returns pot0.
- R6: A NACK from the controller after a read byte ends the transfer. SDA stays released until the next START.
- R7: In a write data byte, bits 7:6 select the register (00 pot0, 01 pot1, 10 config) and bits 5:0 give the new value. Several bytes can be written in one transaction. Select 11 is acknowledged and discarded.
- R8: While `busy` is high, the address byte is not acknowledged and the transaction has no effect.
- R9: A STOP that ends an acknowledged write transaction raises `wr_done` for exactly one cycle. `wr_changed` is high in that cycle only if at least one written value differed from the stored one.
- R10: SCL and SDA each pass through a two-flop synchronizer. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After reset all three values are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| addr_pins | input | 3 | Low three bits of the device address |
| busy | input | 1 | Nonvolatile update in progress; address is refused |
| pot0 | output | 6 | Wiper 0 setting |
| pot1 | output | 6 | Wiper 1 setting |
| cfg | output | 6 | Configuration value |
| wr_done | output | 1 | One-cycle pulse at the STOP of a write transaction |
| wr_changed | output | 1 | Valid with `wr_done`: some value changed |

## Verification
The bench uses the default two synchronizer stages and the fixed 0101 upper address nibble. This short pipeline lets a bus quarter period of eight system clocks keep every edge well clear of the detection delay. The low address bits are swept fully: all eight pin settings against all eight low address bits, which covers every match and mismatch. Wiper and configuration values are stepped across the six-bit range. Each step is read back through seven bytes, so the wrap appears in every pass. Separate transactions cover busy polling, a foreign address, select 11, a repeated START and the release after a NACK.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
  localparam int SEL_W    = 2;
  localparam int VAL_W    = 6;
  localparam int BYTE_W   = SEL_W + VAL_W;
  localparam int NUM_REGS = 3;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_AACK  = 3'd2,
    ST_WDATA = 3'd3,
    ST_WACK  = 3'd4,
    ST_RDATA = 3'd5,
    ST_RACK  = 3'd6,
    ST_SKIP  = 3'd7
  } tgt_state_t;
endpackage

// File: rtl/wpot_bus_sync.sv
module wpot_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/wpot_regs.sv
module wpot_regs
  import wpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [VAL_W-1:0]  wr_val,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              wr_diff,
  output logic [VAL_W-1:0]  pot0,
  output logic [VAL_W-1:0]  pot1,
  output logic [VAL_W-1:0]  cfg
);
  logic [VAL_W-1:0] val_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q[g] <= '0;
      else if (hit) val_q[g] <= wr_val;
    end
  end

  logic [VAL_W-1:0] cur_wr, cur_rd;
  always_comb begin
    case (wr_sel)
      2'd0:    cur_wr = val_q[0];
      2'd1:    cur_wr = val_q[1];
      default: cur_wr = val_q[2];
    endcase
    case (rd_sel)
      2'd0:    cur_rd = val_q[0];
      2'd1:    cur_rd = val_q[1];
      default: cur_rd = val_q[2];
    endcase
  end

  assign wr_diff = (wr_sel != 2'd3) && (cur_wr != wr_val);
  assign rd_byte = {rd_sel, cur_rd};
  assign pot0    = val_q[0];
  assign pot1    = val_q[1];
  assign cfg     = val_q[2];
endmodule

// File: rtl/wpot_tgt_fsm.sv
module wpot_tgt_fsm
  import wpot_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        addr_pins,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              wr_diff,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [VAL_W-1:0]  wr_val,
  output logic [SEL_W-1:0]  rptr,
  output logic              wr_done,
  output logic              wr_changed,
  output tgt_state_t        state_o
);
  tgt_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [SEL_W-1:0]  rp_q, rp_d;
  logic rw_q, rw_d, oe_q, oe_d, ack_q, ack_d;
  logic wtx_q, wtx_d, dirty_q, dirty_d, done_q, done_d, chg_q, chg_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; rp_d = rp_q;
    rw_d = rw_q; oe_d = oe_q; ack_d = ack_q;
    wtx_d = wtx_q; dirty_d = dirty_q;
    done_d = 1'b0; chg_d = 1'b0; wr_en = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0;
      done_d = wtx_q; chg_d = wtx_q & dirty_q;
      wtx_d = 1'b0; dirty_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0; rp_d = '0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[BYTE_W-2:0], sda_s}; cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            rw_d = sh_q[0];
            if (sh_q[7:1] == {ADDR_HI, addr_pins} && !busy) begin
              st_d = ST_AACK; oe_d = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = ST_RDATA; sh_d = rd_byte; oe_d = ~rd_byte[BYTE_W-1];
          end else begin
            st_d = ST_WDATA; oe_d = 1'b0; wtx_d = 1'b1;
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_d = {sh_q[BYTE_W-2:0], sda_s}; cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            st_d = ST_WACK; oe_d = 1'b1; wr_en = 1'b1;
            if (wr_diff) dirty_d = 1'b1;
          end
        end
        ST_WACK: if (scl_fall) begin
          st_d = ST_WDATA; cnt_d = '0; oe_d = 1'b0;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W)) begin
              st_d = ST_RACK; oe_d = 1'b0;
            end else begin
              oe_d = ~sh_q[3'd7 - cnt_q[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
            if (!sda_s) rp_d = (rp_q == SEL_W'(NUM_REGS-1)) ? '0 : rp_q + 1'b1;
          end else if (scl_fall) begin
            if (ack_q) begin
              st_d = ST_RDATA; cnt_d = '0; sh_d = rd_byte; oe_d = ~rd_byte[BYTE_W-1];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; rp_q <= '0;
      rw_q <= 1'b0; oe_q <= 1'b0; ack_q <= 1'b0;
      wtx_q <= 1'b0; dirty_q <= 1'b0; done_q <= 1'b0; chg_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; rp_q <= rp_d;
      rw_q <= rw_d; oe_q <= oe_d; ack_q <= ack_d;
      wtx_q <= wtx_d; dirty_q <= dirty_d; done_q <= done_d; chg_q <= chg_d;
    end
  end

  assign sda_oe     = oe_q;
  assign wr_sel     = sh_q[BYTE_W-1:VAL_W];
  assign wr_val     = sh_q[VAL_W-1:0];
  assign rptr       = rp_q;
  assign wr_done    = done_q;
  assign wr_changed = chg_q;
  assign state_o    = st_q;
endmodule

// File: rtl/wpot_i2c_target.sv
module wpot_i2c_target
  import wpot_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       addr_pins,
  input  logic             busy,
  output logic [VAL_W-1:0] pot0,
  output logic [VAL_W-1:0] pot1,
  output logic [VAL_W-1:0] cfg,
  output logic             wr_done,
  output logic             wr_changed
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, wr_diff;
  logic [SEL_W-1:0]  wr_sel, rptr;
  logic [VAL_W-1:0]  wr_val;
  logic [BYTE_W-1:0] rd_byte;
  tgt_state_t        fsm_state;

  wpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  wpot_tgt_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_pins(addr_pins), .busy(busy), .rd_byte(rd_byte), .wr_diff(wr_diff),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .rptr(rptr), .wr_done(wr_done), .wr_changed(wr_changed), .state_o(fsm_state)
  );

  wpot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .rd_sel(rptr), .rd_byte(rd_byte), .wr_diff(wr_diff),
    .pot0(pot0), .pot1(pot1), .cfg(cfg)
  );
endmodule

// File: rtl/wpot_chk.sv
module wpot_chk
  import wpot_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             busy,
  input tgt_state_t       fsm_state,
  input logic [SEL_W-1:0] rptr,
  input logic             wr_done,
  input logic             wr_changed
);
  // R2: the data line is only changed while the clock is low
  a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R3: silent while skipping a foreign transaction
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_SKIP) |-> !sda_oe);

  // R4: the read pointer leaves the config slot only towards pot0
  a_r4_wrap_to_pot0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rptr) == 2'd2 && rptr != 2'd2) |-> (rptr == 2'd0));

  // R5: entering address reception leaves the pointer at pot0
  a_r5_start_resets_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fsm_state) != ST_ADDR && fsm_state == ST_ADDR) |-> (rptr == 2'd0));

  // R6: a NACK leaves the line released
  a_r6_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fsm_state) == ST_RACK && fsm_state == ST_SKIP) |-> !sda_oe);

  // R8: no address acknowledge is begun while busy
  a_r8_busy_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fsm_state) == ST_ADDR && fsm_state == ST_AACK) |-> !$past(busy));

  // R9: completion is a single-cycle pulse, and the flag rides on it
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  a_r9_changed_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_changed |-> wr_done);
endmodule

bind wpot_i2c_target wpot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy),
  .fsm_state(fsm_state), .rptr(rptr), .wr_done(wr_done), .wr_changed(wr_changed)
);

// File: tb/tb_wpot_i2c_target.sv
`timescale 1ns/1ps
module tb_wpot_i2c_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1;
  logic [2:0] addr_pins = 3'd0;
  logic busy = 1'b0;
  logic sda_oe, wr_done, wr_changed;
  logic [5:0] pot0, pot1, cfg;
  wire sda_line = sda_d & ~sda_oe;

  always #2.5 clk = ~clk;

  wpot_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .busy(busy), .pot0(pot0), .pot1(pot1), .cfg(cfg),
    .wr_done(wr_done), .wr_changed(wr_changed)
  );

  int checks = 0, fails = 0, done_cnt = 0;
  logic last_chg = 1'b0;
  logic [5:0] m [3];
  bit finished = 0;

  always @(posedge clk) if (rst_n && wr_done) begin
    done_cnt <= done_cnt + 1;
    last_chg <= wr_changed;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_d = 1'b1; q(); scl_d = 1'b1; q(); sda_d = 1'b0; q(); scl_d = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_d = 1'b0; q(); scl_d = 1'b1; q(); sda_d = 1'b1; q(); q();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_d = b[i]; q(); scl_d = 1'b1; q(); q(); scl_d = 1'b0;
    end
    sda_d = 1'b1; q(); scl_d = 1'b1; q(); ack = ~sda_line; q(); scl_d = 1'b0;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_d = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_d = 1'b1; q(); b[i] = sda_line; q(); scl_d = 1'b0;
    end
    sda_d = give_ack ? 1'b0 : 1'b1; q(); scl_d = 1'b1; q(); q(); scl_d = 1'b0;
    q(); sda_d = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    return {2'(k % 3), m[k % 3]};
  endfunction

  task automatic wr_txn(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input int n, input string tag);
    bit a;
    i2c_start();
    wr_byte({4'b0101, addr_pins, 1'b0}, a);
    chk(a, tag, a, 1);
    wr_byte(b0, a); chk(a, tag, a, 1);
    if (n > 1) begin wr_byte(b1, a); chk(a, tag, a, 1); end
    if (n > 2) begin wr_byte(b2, a); chk(a, tag, a, 1); end
    i2c_stop();
  endtask

  task automatic rd_txn(input int n, input string tag);
    bit a;
    logic [7:0] b;
    i2c_start();
    wr_byte({4'b0101, addr_pins, 1'b1}, a);
    chk(a, tag, a, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, b);
      chk(b == exp_rd(k), tag, b, exp_rd(k));
    end
    i2c_stop();
  endtask

  initial begin
    bit a;
    int d0;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    m[0] = 0; m[1] = 0; m[2] = 0;
    // R10: reset state
    chk(pot0 == 0 && pot1 == 0 && cfg == 0, "R10 reset values", {pot0, pot1, cfg}, 0);
    chk(!sda_oe && !wr_done, "R10 released after reset", sda_oe, 0);

    // R1: full sweep of pin settings against low address bits
    for (int p = 0; p < 8; p++) begin
      addr_pins = 3'(p);
      for (int lo = 0; lo < 8; lo++) begin
        i2c_start();
        wr_byte({4'b0101, 3'(lo), 1'b0}, a);
        i2c_stop();
        chk(a == (lo == p), "R1 address match", a, lo == p);
      end
    end
    addr_pins = 3'b101;
    i2c_start(); wr_byte({4'b0111, addr_pins, 1'b0}, a); i2c_stop();
    chk(!a, "R1 upper nibble mismatch", a, 0);

    // R7 R4 R9: multi-register writes then wrapping reads
    for (int v = 0; v < 64; v += 9) begin
      logic [5:0] n0, n1, n2;
      bit diff;
      n0 = 6'(v); n1 = 6'(63 - v); n2 = 6'(v) ^ 6'h15;
      diff = (n0 != m[0]) || (n1 != m[1]) || (n2 != m[2]);
      d0 = done_cnt;
      wr_txn({2'b00, n0}, {2'b01, n1}, {2'b10, n2}, 3, "R7 write ack");
      m[0] = n0; m[1] = n1; m[2] = n2;
      chk(done_cnt == d0 + 1, "R9 one done pulse", done_cnt - d0, 1);
      chk(last_chg == diff, "R9 changed flag", last_chg, diff);
      chk(pot0 == m[0] && pot1 == m[1] && cfg == m[2], "R7 outputs",
          {pot0, pot1, cfg}, {m[0], m[1], m[2]});
      rd_txn(7, "R4 cyclic read");
    end

    // R5: single read gives pot0, repeated START restarts order
    rd_txn(1, "R5 single read");
    i2c_start();
    wr_byte({4'b0101, addr_pins, 1'b1}, a);
    rd_byte(1'b1, b); rd_byte(1'b0, b);
    i2c_start();
    wr_byte({4'b0101, addr_pins, 1'b1}, a);
    rd_byte(1'b0, b);
    chk(b == exp_rd(0), "R5 repeated start resets order", b, exp_rd(0));
    i2c_stop();

    // R6: after NACK the target leaves SDA alone
    i2c_start();
    wr_byte({4'b0101, addr_pins, 1'b1}, a);
    rd_byte(1'b0, b);
    for (int i = 0; i < 9; i++) begin
      q(); scl_d = 1'b1; q();
      chk(sda_line == 1'b1, "R6 released after NACK", sda_line, 1);
      q(); scl_d = 1'b0;
    end
    q(); i2c_stop();

    // R7: select 11 discarded; R9: rewrite of equal value
    d0 = done_cnt;
    wr_txn(8'hFF, 8'h00, 8'h00, 1, "R7 select 11 ack");
    chk(pot0 == m[0] && pot1 == m[1] && cfg == m[2], "R7 select 11 no effect",
        {pot0, pot1, cfg}, {m[0], m[1], m[2]});
    chk(done_cnt == d0 + 1 && !last_chg, "R9 unchanged flag", last_chg, 0);
    wr_txn({2'b01, m[1]}, 8'h00, 8'h00, 1, "R9 same value");
    chk(!last_chg, "R9 same value no change", last_chg, 0);
    m[1] = m[1] ^ 6'h01;
    wr_txn({2'b01, m[1]}, 8'h00, 8'h00, 1, "R9 new value");
    chk(last_chg && pot1 == m[1], "R9 new value changed", last_chg, 1);

    // R8: busy refuses the address, polling succeeds afterwards
    busy = 1'b1;
    d0 = done_cnt;
    i2c_start();
    wr_byte({4'b0101, addr_pins, 1'b0}, a);
    chk(!a, "R8 no ack while busy", a, 0);
    wr_byte({2'b00, ~m[0]}, a);
    chk(!a, "R8 data ignored while busy", a, 0);
    i2c_stop();
    chk(pot0 == m[0] && done_cnt == d0, "R8 no effect", pot0, m[0]);
    busy = 1'b0;
    i2c_start(); wr_byte({4'b0101, addr_pins, 1'b0}, a); i2c_stop();
    chk(a, "R8 ack after busy drops", a, 1);

    // R3: foreign address, following data must not land
    i2c_start();
    wr_byte({4'b0101, addr_pins ^ 3'b010, 1'b0}, a);
    chk(!a, "R3 foreign address", a, 0);
    wr_byte({2'b10, ~m[2]}, a);
    chk(!a, "R3 data not acked", a, 0);
    i2c_stop();
    chk(cfg == m[2], "R3 config unchanged", cfg, m[2]);
    rd_txn(3, "R3 readback");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule